// File: doc/BRIEF.md
# Interrupt State, Enable and Test-Injection Registers

This block is the interrupt register slice of a peripheral with a configurable number of interrupt sources. It keeps a sticky pending-state bit per source, an enable mask per source, and a write-only injection register. Single-cycle event pulses from the peripheral's logic set pending bits. Software acknowledges a pending bit by writing a one to it in the state register.

Each interrupt line is driven from the pending bit ANDed with the enable bit. The injection register lets software set pending bits as if the matching hardware events had fired. This lets interrupt routing and handler code be tested without provoking the real conditions.

Access is through a plain register port: an address, write data, a write strobe and combinational read data. Word offsets are 0 for pending state, 1 for enable and 2 for injection. All other offsets are unmapped.

Top module: `intr_bank`

## Requirements
- R1: After reset the pending state, the enable mask and every interrupt line are zero.
- R2: A write to offset 1 loads the enable mask from the write data. A read of offset 1 returns the mask on the cycle after the write.
- R3: An event input held high for one clock cycle sets the matching pending bit, and the bit is visible from the next cycle.
- R4: A write to offset 2 sets every pending bit whose write-data bit is one. A read of offset 0 afterwards returns those bits ORed with the bits already pending.
- R5: A write to offset 0 clears every pending bit whose write-data bit is one. Bits written as zero keep their value.
- R6: Interrupt line i is high exactly when pending bit i and enable bit i are both one, in the same cycle.
- R7: When an event for a bit arrives in the same cycle as a clearing write for that bit, the bit stays set.
- R8: A pending bit stays set while its source is disabled, until software clears it. Setting the enable bit later raises the line.
- R9: A read of offset 2 returns zero. An injection write sets bits once and has no lasting effect: bits cleared after the write stay clear.
- R10: A read of offset 3 or any higher offset returns zero. Writes there change neither the state nor the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Word offset of the register being accessed |
| reg_wdata | input | NUM_SRC | Write data |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | NUM_SRC | Combinational read data for reg_addr |
| evt_i | input | NUM_SRC | Event pulses from the peripheral, one per source |
| irq_o | output | NUM_SRC | Interrupt lines |

## Verification
The bench applies all 256 enable masks against a pending pattern that changes with the mask, and compares the lines to the arithmetic AND. A design that gated on the enable mask alone, or that registered the lines a cycle late, would fail these comparisons.

Each source is injected and cleared on its own, to catch crossed or stuck bit lanes. Pending bits are set while disabled, to catch a design that dropped or refused masked pending bits.

An event is placed in the same cycle as a clear of the same bit. A design that gave priority to the clear would lose the event.

Offsets 2 and above are read back, and offsets 3 and above are written. A design that stored the injection value or decoded addresses partially would return nonzero data or corrupt the state or the enable mask.

// File: rtl/intr_bank_pkg.sv
package intr_bank_pkg;
   localparam int unsigned OFS_STATE  = 0;
   localparam int unsigned OFS_ENABLE = 1;
   localparam int unsigned OFS_INJECT = 2;

   typedef enum logic [1:0] {
      SEL_STATE  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_INJECT = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/intr_bank_decode.sv
module intr_bank_decode
   import intr_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output reg_sel_e          sel,
   output logic              wr_state,
   output logic              wr_enable,
   output logic              wr_inject
);
   localparam logic [ADDR_W-1:0] A_STATE  = ADDR_W'(OFS_STATE);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_INJECT = ADDR_W'(OFS_INJECT);

   initial begin
      if (ADDR_W < 2) $error("intr_bank_decode: ADDR_W must be at least 2");
   end

   always_comb begin
      if (addr == A_STATE)       sel = SEL_STATE;
      else if (addr == A_ENABLE) sel = SEL_ENABLE;
      else if (addr == A_INJECT) sel = SEL_INJECT;
      else                       sel = SEL_NONE;
   end

   assign wr_state  = we && (sel == SEL_STATE);
   assign wr_enable = we && (sel == SEL_ENABLE);
   assign wr_inject = we && (sel == SEL_INJECT);
endmodule

// File: rtl/intr_bank_state.sv
module intr_bank_state #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] inject,
   input  logic [NUM_SRC-1:0] clear,
   output logic [NUM_SRC-1:0] pending
);
   initial begin
      if (NUM_SRC < 1) $error("intr_bank_state: NUM_SRC must be at least 1");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic set_now;
      assign set_now = evt[i] | inject[i];

      // Set outranks clear so that a simultaneous event is never lost.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pending[i] <= 1'b0;
         else if (set_now)  pending[i] <= 1'b1;
         else if (clear[i]) pending[i] <= 1'b0;
      end

      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> pending[i]);                                    // R3
      AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         inject[i] |=> pending[i]);                                 // R4
      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (clear[i] && !evt[i] && !inject[i]) |=> !pending[i]);      // R5
      AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (clear[i] && evt[i]) |=> pending[i]);                      // R7
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (pending[i] && !clear[i]) |=> pending[i]);                 // R8
      AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pending[i]) |-> $past(evt[i] || inject[i]));         // R3
   end
endmodule

// File: rtl/intr_bank_enable.sv
module intr_bank_enable #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask <= '0;
      else if (wr) mask <= wdata;
   end

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mask));                                       // R10
   AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (mask == $past(wdata)));                               // R2
endmodule

// File: rtl/intr_bank_rdmux.sv
module intr_bank_rdmux
   import intr_bank_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8
) (
   input  reg_sel_e           sel,
   input  logic [NUM_SRC-1:0] pending,
   input  logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] rdata
);
   always_comb begin
      unique case (sel)
         SEL_STATE:  rdata = pending;
         SEL_ENABLE: rdata = mask;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/intr_bank.sv
module intr_bank
   import intr_bank_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [NUM_SRC-1:0] reg_wdata,
   input  logic               reg_we,
   output logic [NUM_SRC-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic [NUM_SRC-1:0] irq_o
);
   localparam logic [NUM_SRC-1:0] NONE = '0;

   reg_sel_e           sel;
   logic               wr_state, wr_enable, wr_inject;
   logic [NUM_SRC-1:0] pending, mask, clear_v, inject_v, irq_raw;

   initial begin
      if ((1 << ADDR_W) <= OFS_INJECT) $error("intr_bank: ADDR_W too narrow for the map");
   end

   intr_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(reg_addr), .we(reg_we), .sel(sel),
      .wr_state(wr_state), .wr_enable(wr_enable), .wr_inject(wr_inject)
   );

   assign clear_v  = wr_state  ? reg_wdata : NONE;
   assign inject_v = wr_inject ? reg_wdata : NONE;

   intr_bank_state #(.NUM_SRC(NUM_SRC)) u_state (
      .clk(clk), .rst_n(rst_n), .evt(evt_i),
      .inject(inject_v), .clear(clear_v), .pending(pending)
   );

   intr_bank_enable #(.NUM_SRC(NUM_SRC)) u_en (
      .clk(clk), .rst_n(rst_n), .wr(wr_enable), .wdata(reg_wdata), .mask(mask)
   );

   intr_bank_rdmux #(.NUM_SRC(NUM_SRC)) u_rd (
      .sel(sel), .pending(pending), .mask(mask), .rdata(reg_rdata)
   );

   assign irq_raw = pending & mask;

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= '0;
         else        irq_o <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end

   AST_INJECT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_INJECT)) |-> (reg_rdata == NONE));   // R9
   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > ADDR_W'(OFS_INJECT)) |-> (reg_rdata == NONE));    // R10
   AST_UNMAPPED_WRITE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr > ADDR_W'(OFS_INJECT) && evt_i == NONE)
      |=> (pending == $past(pending)));                             // R10
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_irq_chk
      if (!IRQ_REG) begin : g_comb_chk
         AST_LINE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] |-> (u_state.pending[k] && u_en.mask[k]));     // R6
      end
   end
endmodule

// File: tb/intr_bank_test.sv
module intr_bank_test;
   localparam int N  = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [N-1:0]  reg_wdata = '0;
   logic          reg_we = 1'b0;
   logic [N-1:0]  reg_rdata;
   logic [N-1:0]  evt_i = '0;
   logic [N-1:0]  irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [N-1:0] m_state = '0;
   logic [N-1:0] m_en    = '0;

   always #2.5 clk = ~clk;

   intr_bank #(.NUM_SRC(N), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock cycle with the given stimulus, then return to idle.
   task automatic cyc(input logic [AW-1:0] a, input logic [N-1:0] d,
                      input logic we, input logic [N-1:0] ev);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = we; evt_i = ev;
      @(posedge clk);
      #1;
      reg_we = 1'b0; evt_i = '0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] v);
      @(negedge clk);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic check_model(input string req);
      logic [N-1:0] v;
      rd(AW'(0), v); chk(req, v, m_state);
      rd(AW'(1), v); chk(req, v, m_en);
      chk(req, irq_o, m_state & m_en);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [N-1:0] v;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 state", reg_rdata, '0);
      chk("R1 irq", irq_o, '0);
      @(negedge clk); rst_n = 1'b1;
      check_model("R1");

      // R3: each event lane alone, then clear it (R5)
      for (int i = 0; i < N; i++) begin
         cyc(AW'(0), '0, 1'b0, N'(1) << i);
         m_state = N'(1) << i;
         check_model("R3");
         cyc(AW'(0), N'(1) << i, 1'b1, '0);
         m_state = '0;
         check_model("R5");
      end

      // R4 / R9: injection per lane accumulates, read of offset 2 is zero
      for (int i = 0; i < N; i++) begin
         cyc(AW'(2), N'(1) << i, 1'b1, '0);
         m_state |= N'(1) << i;
         check_model("R4");
         rd(AW'(2), v); chk("R9 read", v, '0);
      end
      // R5: partial clear leaves zero-written bits
      cyc(AW'(0), 8'h3C, 1'b1, '0);
      m_state &= ~8'h3C;
      check_model("R5 partial");
      cyc(AW'(0), 8'hFF, 1'b1, '0);
      m_state = '0;
      // R9: injection leaves nothing behind
      repeat (3) @(posedge clk);
      check_model("R9 no lasting");

      // R2 / R6: all enable masks against a varying pending pattern
      for (int e = 0; e < 256; e++) begin
         logic [N-1:0] p;
         p = N'(e) ^ 8'hA5 ^ N'((e * 7) & 8'hFF);
         cyc(AW'(0), 8'hFF, 1'b1, '0);
         cyc(AW'(2), p, 1'b1, '0);
         cyc(AW'(1), N'(e), 1'b1, '0);
         m_state = p; m_en = N'(e);
         rd(AW'(1), v); chk("R2", v, m_en);
         chk("R6", irq_o, m_state & m_en);
      end

      // R8: pending while disabled stays, line rises on enable
      cyc(AW'(1), '0, 1'b1, '0); m_en = '0;
      cyc(AW'(0), 8'hFF, 1'b1, '0); m_state = '0;
      cyc(AW'(0), '0, 1'b0, 8'h81); m_state = 8'h81;
      repeat (5) @(posedge clk);
      check_model("R8 held");
      cyc(AW'(1), 8'h01, 1'b1, '0); m_en = 8'h01;
      check_model("R8 enable");
      chk("R8 line", irq_o, 8'h01);

      // R7: event collides with clear of the same bit
      cyc(AW'(0), 8'hFF, 1'b1, 8'h11);
      m_state = 8'h11;
      check_model("R7");

      // R10: unmapped offsets read zero, writes ignored
      cyc(AW'(1), 8'hC3, 1'b1, '0); m_en = 8'hC3;
      for (int a = 3; a < 16; a++) begin
         rd(AW'(a), v); chk("R10 read", v, '0);
         cyc(AW'(a), 8'hFF, 1'b1, '0);
         check_model("R10 write");
      end

      // R1: reset in the middle clears everything
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R1 irq reset", irq_o, '0);
      @(negedge clk); rst_n = 1'b1;
      m_state = '0; m_en = '0;
      check_model("R1 again");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule